// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel-request timing for a parallel RGB panel that is driven from a dot clock. Software-style configuration inputs set the total pixel clocks per line and the total lines per frame, blanking included. They also set the two sync pulse widths, a horizontal and a vertical wait measured from the end of each sync pulse, and the number of valid pixels and lines in the active window. Each of the three panel outputs has its own active-level select. A further select tells the pixel path whether to launch data on the falling or the rising edge.

Two controls start the block. The sync-enable input starts the counters and the sync outputs. A run request then starts pixel transfer, and it is accepted only while sync is already on and dot-clock mode is selected. Once dot-clock mode is dropped, the run status stays up until the pixel FIFO reports empty. The configuration is copied into shadow registers while the block is idle and at every frame boundary. A write in the middle of a frame therefore never tears the picture. A single-cycle frame-done pulse marks the last active pixel of a frame. The current pixel and line counters are brought out for the data path.

Top module: `lcd_sync_timer`

## Requirements
- R1: While `sync_en` is low, `pix_cnt` and `line_cnt` are 0 one clock later. `hsync`, `vsync` and `de` sit at their inactive level, and `pix_req` and `frame_done` are 0.
- R2: With `sync_en` high, `pix_cnt` counts 0 up to `cfg_htotal`-1 and then wraps to 0. `hsync` is active exactly while `pix_cnt` < `cfg_hsync_w`.
- R3: `line_cnt` advances by one when `pix_cnt` wraps and returns to 0 after `cfg_vtotal`-1. `vsync` is active exactly while `line_cnt` < `cfg_vsync_w`.
- R4: `pix_req` is 1 exactly when `run_busy` is 1 and both of these hold: `pix_cnt` lies in [`cfg_hsync_w`+`cfg_hwait`, `cfg_hsync_w`+`cfg_hwait`+`cfg_hvalid`), and `line_cnt` lies in [`cfg_vsync_w`+`cfg_vwait`, `cfg_vsync_w`+`cfg_vwait`+`cfg_vlines`).
- R5: An active-level select of 1 makes its output active high. A select of 0 makes it active low. `cfg_hs_hi` controls `hsync`, `cfg_vs_hi` controls `vsync` and `cfg_de_hi` controls `de`, and `de` is the level-adjusted copy of `pix_req`.
- R6: `launch_fall` shows the edge select `cfg_fall` (1 = launch on the falling edge) held in the shadow registers.
- R7: `run_busy` rises only on a clock where `run_set`, `sync_en` and `mode_en` are all 1. It falls only on a clock where `mode_en` is 0 and `fifo_empty` is 1.
- R8: `frame_done` is a one-cycle pulse. It is raised together with the last `pix_req` of the last active line of each frame.
- R9: Configuration values are taken only while `sync_en` is low or on the clock where the counters wrap from the last pixel of the last line. A change made mid-frame first takes effect in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_en | input | 1 | Enables counters and sync outputs |
| mode_en | input | 1 | Dot-clock mode select |
| run_set | input | 1 | Request to start pixel transfer |
| fifo_empty | input | 1 | Pixel FIFO has drained |
| cfg_htotal | input | HW | Pixel clocks per line, blanking included |
| cfg_hsync_w | input | HW | Horizontal sync width in clocks |
| cfg_hwait | input | HW | Clocks from end of horizontal sync to first valid pixel |
| cfg_hvalid | input | HW | Valid pixels per line |
| cfg_vtotal | input | VW | Lines per frame, blanking included |
| cfg_vsync_w | input | VW | Vertical sync width in lines |
| cfg_vwait | input | VW | Lines from end of vertical sync to first active line |
| cfg_vlines | input | VW | Active lines per frame |
| cfg_hs_hi | input | 1 | Horizontal sync active high |
| cfg_vs_hi | input | 1 | Vertical sync active high |
| cfg_de_hi | input | 1 | Data enable active high |
| cfg_fall | input | 1 | Launch data on falling edge |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| launch_fall | output | 1 | Edge select for pixel launch |
| pix_req | output | 1 | Active-high pixel request strobe |
| frame_done | output | 1 | Last active pixel of the frame |
| run_busy | output | 1 | Pixel transfer running |
| pix_cnt | output | HW | Pixel counter within line |
| line_cnt | output | VW | Line counter within frame |

## Verification
Two functions can fall on the same clock edge: the frame wrap, which reloads the shadow configuration, and a configuration write. The bench changes the line length and the horizontal sync level in the middle of a frame, while its own cycle model keeps the old values. It then compares every output on every clock, so a reload that comes too early or too late shows up as a wrong sync level or a wrong counter wrap. Two more pairs fall on the same clock. The last active pixel and the frame-done pulse are checked together on each clock. The drop of dot-clock mode is checked against a FIFO that is still full and then against an empty one.

// File: rtl/lcd_sync_timer.sv
module lcd_sync_timer #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_en,
  input  logic          mode_en,
  input  logic          run_set,
  input  logic          fifo_empty,
  input  logic [HW-1:0] cfg_htotal,
  input  logic [HW-1:0] cfg_hsync_w,
  input  logic [HW-1:0] cfg_hwait,
  input  logic [HW-1:0] cfg_hvalid,
  input  logic [VW-1:0] cfg_vtotal,
  input  logic [VW-1:0] cfg_vsync_w,
  input  logic [VW-1:0] cfg_vwait,
  input  logic [VW-1:0] cfg_vlines,
  input  logic          cfg_hs_hi,
  input  logic          cfg_vs_hi,
  input  logic          cfg_de_hi,
  input  logic          cfg_fall,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          launch_fall,
  output logic          pix_req,
  output logic          frame_done,
  output logic          run_busy,
  output logic [HW-1:0] pix_cnt,
  output logic [VW-1:0] line_cnt
);
  localparam int HX = HW + 2;
  localparam int VX = VW + 2;

  logic [HW-1:0] s_ht, s_hsw, s_hwt, s_hv;
  logic [VW-1:0] s_vt, s_vsw, s_vwt, s_vl;
  logic          s_hs_hi, s_vs_hi, s_de_hi, s_fall;
  logic [HW-1:0] hc;
  logic [VW-1:0] vc;
  logic          running;

  logic [HX-1:0] h_pos, h_beg, h_end;
  logic [VX-1:0] v_pos, v_beg, v_end;
  logic          h_last, v_last, wrap, load;
  logic          h_act, v_act, hs_on, vs_on;

  assign h_pos  = HX'(hc);
  assign v_pos  = VX'(vc);
  assign h_beg  = HX'(s_hsw) + HX'(s_hwt);
  assign h_end  = h_beg + HX'(s_hv);
  assign v_beg  = VX'(s_vsw) + VX'(s_vwt);
  assign v_end  = v_beg + VX'(s_vl);
  assign h_last = h_pos + HX'(1) >= HX'(s_ht);
  assign v_last = v_pos + VX'(1) >= VX'(s_vt);
  assign wrap   = h_last && v_last;
  assign load   = !sync_en || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s_ht, s_hsw, s_hwt, s_hv} <= '0;
      {s_vt, s_vsw, s_vwt, s_vl} <= '0;
      {s_hs_hi, s_vs_hi, s_de_hi, s_fall} <= '0;
    end else if (load) begin
      s_ht  <= cfg_htotal;
      s_hsw <= cfg_hsync_w;
      s_hwt <= cfg_hwait;
      s_hv  <= cfg_hvalid;
      s_vt  <= cfg_vtotal;
      s_vsw <= cfg_vsync_w;
      s_vwt <= cfg_vwait;
      s_vl  <= cfg_vlines;
      {s_hs_hi, s_vs_hi, s_de_hi, s_fall} <= {cfg_hs_hi, cfg_vs_hi, cfg_de_hi, cfg_fall};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (!sync_en) begin
      hc <= '0;
      vc <= '0;
    end else if (h_last) begin
      hc <= '0;
      vc <= v_last ? '0 : vc + VW'(1);
    end else begin
      hc <= hc + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      running <= 1'b0;
    else if (run_set && sync_en && mode_en)
      running <= 1'b1;
    else if (!mode_en && fifo_empty)
      running <= 1'b0;
  end

  assign hs_on = sync_en && (hc < s_hsw);
  assign vs_on = sync_en && (vc < s_vsw);
  assign h_act = (h_pos >= h_beg) && (h_pos < h_end);
  assign v_act = (v_pos >= v_beg) && (v_pos < v_end);

  assign pix_req     = sync_en && running && h_act && v_act;
  assign frame_done  = pix_req && (h_pos + HX'(1) == h_end) && (v_pos + VX'(1) == v_end);
  assign hsync       = ~(hs_on ^ s_hs_hi);
  assign vsync       = ~(vs_on ^ s_vs_hi);
  assign de          = ~(pix_req ^ s_de_hi);
  assign launch_fall = s_fall;
  assign run_busy    = running;
  assign pix_cnt     = hc;
  assign line_cnt    = vc;
endmodule

// File: rtl/lcd_sync_timer_chk.sv
module lcd_sync_timer_chk #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_en,
  input logic          mode_en,
  input logic          run_set,
  input logic          fifo_empty,
  input logic          pix_req,
  input logic          frame_done,
  input logic          run_busy,
  input logic [HW-1:0] pix_cnt,
  input logic [VW-1:0] line_cnt
);
  // R1
  idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (pix_cnt == '0 && line_cnt == '0));

  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |-> (!pix_req && !frame_done));

  // R2
  pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && $past(sync_en) && pix_cnt != '0) |-> pix_cnt == $past(pix_cnt) + HW'(1));

  // R4
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |-> run_busy);

  // R7
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_busy) |-> $past(run_set && sync_en && mode_en));

  // R7
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_busy) |-> $past(!mode_en && fifo_empty));

  // R8
  done_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> pix_req);
endmodule

bind lcd_sync_timer lcd_sync_timer_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .mode_en(mode_en),
  .run_set(run_set), .fifo_empty(fifo_empty), .pix_req(pix_req),
  .frame_done(frame_done), .run_busy(run_busy), .pix_cnt(pix_cnt),
  .line_cnt(line_cnt)
);

// File: tb/test_lcd_sync_timer.sv
module test_lcd_sync_timer;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic sync_en = 0, mode_en = 0, run_set = 0, fifo_empty = 0;
  logic [HW-1:0] cfg_htotal = 10, cfg_hsync_w = 2, cfg_hwait = 1, cfg_hvalid = 5;
  logic [VW-1:0] cfg_vtotal = 6, cfg_vsync_w = 1, cfg_vwait = 1, cfg_vlines = 3;
  logic cfg_hs_hi = 0, cfg_vs_hi = 0, cfg_de_hi = 1, cfg_fall = 0;
  logic hsync, vsync, de, launch_fall, pix_req, frame_done, run_busy;
  logic [HW-1:0] pix_cnt;
  logic [VW-1:0] line_cnt;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_sync_timer #(.HW(HW), .VW(VW)) i_lcd_sync_timer (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic t_reset_idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "pix_cnt", pix_cnt, 0);
    chk("R1", "line_cnt", line_cnt, 0);
    chk("R1", "hsync idle (active low)", hsync, 1);
    chk("R1", "vsync idle (active low)", vsync, 1);
    chk("R1", "de idle (active high)", de, 0);
    chk("R1", "pix_req idle", pix_req, 0);
    chk("R7", "run_busy after reset", run_busy, 0);
    @(negedge clk);
    mode_en = 1; run_set = 1;
    @(negedge clk);
    run_set = 0;
    #1;
    chk("R7", "run_set ignored with sync off", run_busy, 0);
    @(negedge clk);
    cfg_fall = 1;
    repeat (2) @(negedge clk);
    #1;
    chk("R6", "launch_fall", launch_fall, 1);
  endtask

  // cycle model of the timing; mid-frame change at cycle chg_at
  task automatic t_frames(input int ncyc, input int chg_at);
    int mht, mhsw, mhwt, mhv, mvt, mvsw, mvwt, mvl;
    bit mhs_hi, mvs_hi, mde_hi;
    int hc = 0, vc = 0, dones = 0;
    bit hon, von, act;
    mht = cfg_htotal; mhsw = cfg_hsync_w; mhwt = cfg_hwait; mhv = cfg_hvalid;
    mvt = cfg_vtotal; mvsw = cfg_vsync_w; mvwt = cfg_vwait; mvl = cfg_vlines;
    mhs_hi = cfg_hs_hi; mvs_hi = cfg_vs_hi; mde_hi = cfg_de_hi;
    @(negedge clk);
    sync_en = 1; run_set = 1;
    for (int i = 0; i < ncyc; i++) begin
      #1;
      hon = hc < mhsw;
      von = vc < mvsw;
      act = (i > 0) && hc >= mhsw + mhwt && hc < mhsw + mhwt + mhv &&
            vc >= mvsw + mvwt && vc < mvsw + mvwt + mvl;
      chk("R2", "pix_cnt", pix_cnt, hc);
      chk("R3", "line_cnt", line_cnt, vc);
      chk("R2", "hsync", hsync, mhs_hi ? hon : !hon);
      chk("R3", "vsync", vsync, mvs_hi ? von : !von);
      chk("R4", "pix_req", pix_req, act);
      chk("R5", "de", de, mde_hi ? act : !act);
      chk("R8", "frame_done", frame_done,
          act && hc == mhsw + mhwt + mhv - 1 && vc == mvsw + mvwt + mvl - 1);
      if (frame_done) dones++;
      if (i == chg_at) begin
        cfg_htotal = 12; cfg_hs_hi = 1;   // R9: must wait for frame wrap
      end
      @(negedge clk);
      run_set = 0;
      if (hc == mht - 1) begin
        hc = 0;
        if (vc == mvt - 1) begin
          vc = 0;
          mht = cfg_htotal; mhsw = cfg_hsync_w; mhwt = cfg_hwait; mhv = cfg_hvalid;
          mvt = cfg_vtotal; mvsw = cfg_vsync_w; mvwt = cfg_vwait; mvl = cfg_vlines;
          mhs_hi = cfg_hs_hi; mvs_hi = cfg_vs_hi; mde_hi = cfg_de_hi;
        end else vc++;
      end else hc++;
    end
    chk("R8", "frame_done pulses", dones, 3);
  endtask

  task automatic t_stop();
    #1;
    chk("R7", "run_busy while running", run_busy, 1);
    mode_en = 0; fifo_empty = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R7", "run_busy held until fifo empty", run_busy, 1);
    fifo_empty = 1;
    @(negedge clk);
    #1;
    chk("R7", "run_busy cleared after drain", run_busy, 0);
    sync_en = 0;
    @(negedge clk);
    #1;
    chk("R1", "pix_cnt after sync off", pix_cnt, 0);
    chk("R1", "line_cnt after sync off", line_cnt, 0);
    chk("R5", "hsync idle (now active high)", hsync, 0);
    chk("R4", "pix_req after stop", pix_req, 0);
  endtask

  initial begin
    t_reset_idle();
    t_frames(200, 70);
    t_stop();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule